// File: doc/BRIEF.md
# Potentiometer Terminal Shutdown Controller

This block holds the digital state for one resistor network of a digital potentiometer. It decides whether each of the three terminal switches is closed: the A end, the wiper and the B end. It also holds the wiper code that selects a tap on the ladder. A single write port loads either a 4-bit terminal configuration word or the wiper code. The serial bus front end and the analog ladder sit outside this block.

Two shutdown sources can force a fixed configuration. One is an asynchronous active-low pin and the other is a software bit inside the configuration word. The forced configuration opens the A end and shorts the wiper to the B end. While it is forced, the per-terminal connect bits are overridden but keep their stored values. The wiper code is never disturbed by shutdown. Writes to either register are still accepted and stored while shutdown is in force, so software can prepare the state the network returns to.

Top module: `pot_term_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no writes, the connect bits for A, W and B read as 1, the software shutdown bit reads as 0 and the wiper code is 8'h80. The outputs then show A, W and B closed, no short and wiper_code 8'h80.
- R2: A write with wr_sel=0 loads wr_data[3:0] into the terminal word on the clock edge where wr_en is sampled high. Bit 0 is the A connect bit, bit 1 the W connect bit, bit 2 the B connect bit and bit 3 the software shutdown bit (1 = shut down).
- R3: A write with wr_sel=1 loads wr_data into the wiper register on the clock edge where wr_en is sampled high. wiper_code always shows that register.
- R4: When the synchronized shutdown pin is low, the outputs are sw_a_en=0, sw_w_en=1, sw_b_en=1 and w_to_b_short=1, whatever the connect bits hold.
- R5: When terminal bit 3 is 1, the outputs take the same forced configuration as in R4.
- R6: The network is forced when either the pin is low or bit 3 is set. When neither holds, sw_a_en, sw_w_en and sw_b_en equal bits 0, 1 and 2, and w_to_b_short is 0.
- R7: Entering and leaving the forced configuration leaves the stored connect bits unchanged. After exit, the outputs again follow those stored bits.
- R8: No shutdown event and no terminal write changes the wiper register. After a shutdown ends, wiper_code still holds the last value written.
- R9: Writes to both registers are accepted during shutdown and take effect once it ends. A wiper write is visible at once.
- R10: w_to_b_short is 1 only in the forced configuration. Whenever it is 1, sw_a_en is 0.
- R11: A change on shdn_n reaches the outputs after exactly two rising clock edges, through a two-flop synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside |
| shdn_n | input | 1 | Asynchronous active-low shutdown pin |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = terminal word, 1 = wiper register |
| wr_data | input | 8 | Write data |
| sw_a_en | output | 1 | A terminal switch closed |
| sw_w_en | output | 1 | Wiper terminal switch closed |
| sw_b_en | output | 1 | B terminal switch closed |
| w_to_b_short | output | 1 | Wiper tied to B (forced shutdown only) |
| wiper_code | output | 8 | Effective wiper code |

## Verification
The hardest situation to reach is a register update that happens while shutdown is forced. Such an update has no visible effect on the switch outputs until the override lifts. The stimulus holds the pin low, or sets the software bit, and then writes new connect bits and wiper codes. It releases the override and checks that the outputs show the values written during shutdown. The bench sweeps all sixteen terminal words against both pin levels, and all 256 wiper codes with the pin alternating.

// File: rtl/pot_term_pkg.sv
package pot_term_pkg;
  localparam int unsigned TERM_W  = 4;
  localparam int unsigned BIT_A   = 0;
  localparam int unsigned BIT_W   = 1;
  localparam int unsigned BIT_B   = 2;
  localparam int unsigned BIT_SSD = 3;

  typedef enum logic {
    SEL_TERM  = 1'b0,
    SEL_WIPER = 1'b1
  } wr_sel_e;

  typedef struct packed {
    logic sw_a;
    logic sw_w;
    logic sw_b;
    logic short_wb;
  } sw_ctrl_t;
endpackage

// File: rtl/pot_rst_sync.sv
module pot_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = 1'b1;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pot_pin_sync.sv
module pot_pin_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic pin_sync
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  generate
    if (STAGES == 1) begin : g_one
      assign stage_d = pin_async;
    end else begin : g_many
      assign stage_d = {stage_q[STAGES-2:0], pin_async};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= {STAGES{RESET_VAL}};
    else        stage_q <= stage_d;
  end

  assign pin_sync = stage_q[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk
      // R11: a rising synchronized level reflects the pin two edges earlier
      p_sync_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pin_sync) |-> $past(pin_async, 2));
      p_sync_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pin_sync) |-> !$past(pin_async, 2));
    end
  endgenerate
endmodule

// File: rtl/pot_regs.sv
module pot_regs
  import pot_term_pkg::*;
#(
  parameter int unsigned WIPER_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  wr_sel_e            wr_sel,
  input  logic [WIPER_W-1:0] wr_data,
  output logic [TERM_W-1:0]  term_q,
  output logic [WIPER_W-1:0] wiper_q
);
  localparam logic [WIPER_W-1:0] WIPER_RST = WIPER_W'(1) << (WIPER_W - 1);
  localparam logic [TERM_W-1:0]  TERM_RST  =
    TERM_W'((1 << BIT_A) | (1 << BIT_W) | (1 << BIT_B));

  logic [TERM_W-1:0]  term_d;
  logic [WIPER_W-1:0] wiper_d;
  logic               term_ld;
  logic               wiper_ld;

  assign term_ld  = wr_en && (wr_sel == SEL_TERM);
  assign wiper_ld = wr_en && (wr_sel == SEL_WIPER);

  always_comb begin
    term_d  = term_q;
    wiper_d = wiper_q;
    if (term_ld)  term_d  = wr_data[TERM_W-1:0];
    if (wiper_ld) wiper_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      term_q  <= TERM_RST;
      wiper_q <= WIPER_RST;
    end else begin
      term_q  <= term_d;
      wiper_q <= wiper_d;
    end
  end

  p_term_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_TERM) |=> term_q == $past(wr_data[TERM_W-1:0]));
  p_wiper_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_WIPER) |=> wiper_q == $past(wr_data));
  p_term_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == SEL_TERM) |=> $stable(term_q));
  p_wiper_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == SEL_WIPER) |=> $stable(wiper_q));
endmodule

// File: rtl/pot_term_mux.sv
module pot_term_mux
  import pot_term_pkg::*;
(
  input  logic              force_sd,
  input  logic [TERM_W-1:0] term_bits,
  output sw_ctrl_t          sw
);
  always_comb begin
    if (force_sd) begin
      sw.sw_a     = 1'b0;
      sw.sw_w     = 1'b1;
      sw.sw_b     = 1'b1;
      sw.short_wb = 1'b1;
    end else begin
      sw.sw_a     = term_bits[BIT_A];
      sw.sw_w     = term_bits[BIT_W];
      sw.sw_b     = term_bits[BIT_B];
      sw.short_wb = 1'b0;
    end
  end

  always_comb begin
    // R10: the short never coexists with a closed A switch
    p_short_opens_a_r10: assert (!(sw.short_wb && sw.sw_a));
  end
endmodule

// File: rtl/pot_term_ctrl.sv
module pot_term_ctrl
  import pot_term_pkg::*;
#(
  parameter int unsigned WIPER_W     = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shdn_n,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [WIPER_W-1:0] wr_data,
  output logic               sw_a_en,
  output logic               sw_w_en,
  output logic               sw_b_en,
  output logic               w_to_b_short,
  output logic [WIPER_W-1:0] wiper_code
);
  logic               rst_sync_n;
  logic               shdn_sync_n;
  logic [TERM_W-1:0]  term_q;
  logic [WIPER_W-1:0] wiper_q;
  logic               force_sd;
  sw_ctrl_t           sw;

  pot_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pot_pin_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_pin_sync (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .pin_async (shdn_n),
    .pin_sync  (shdn_sync_n)
  );

  pot_regs #(.WIPER_W(WIPER_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel_e'(wr_sel)),
    .wr_data (wr_data),
    .term_q  (term_q),
    .wiper_q (wiper_q)
  );

  assign force_sd = !shdn_sync_n || term_q[BIT_SSD];

  pot_term_mux u_mux (
    .force_sd  (force_sd),
    .term_bits (term_q),
    .sw        (sw)
  );

  assign sw_a_en      = sw.sw_a;
  assign sw_w_en      = sw.sw_w;
  assign sw_b_en      = sw.sw_b;
  assign w_to_b_short = sw.short_wb;
  assign wiper_code   = wiper_q;

  p_pin_forces_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !shdn_sync_n |-> (!sw_a_en && sw_w_en && sw_b_en && w_to_b_short));
  p_soft_forces_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    term_q[BIT_SSD] |-> (!sw_a_en && sw_w_en && sw_b_en && w_to_b_short));
  p_normal_follow_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (shdn_sync_n && !term_q[BIT_SSD]) |->
      (!w_to_b_short && sw_a_en == term_q[BIT_A] &&
       sw_w_en == term_q[BIT_W] && sw_b_en == term_q[BIT_B]));
  p_wiper_out_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wiper_code == wiper_q);
endmodule

// File: tb/pot_term_ctrl_tb.sv
module pot_term_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       shdn_n;
  logic       wr_en;
  logic       wr_sel;
  logic [7:0] wr_data;
  logic       sw_a_en, sw_w_en, sw_b_en, w_to_b_short;
  logic [7:0] wiper_code;

  int n_vec  = 0;
  int n_bad  = 0;
  int cycles = 0;
  logic [3:0] exp_term;
  logic [7:0] exp_wiper;

  always #10 clk = ~clk;

  pot_term_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .sw_a_en(sw_a_en),
    .sw_w_en(sw_w_en), .sw_b_en(sw_b_en), .w_to_b_short(w_to_b_short),
    .wiper_code(wiper_code)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run did not finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic pin_lvl);
    logic       frc;
    logic [11:0] exp, act;
    frc = !pin_lvl || exp_term[3];
    exp = frc ? {4'b0111, exp_wiper}
              : {exp_term[0], exp_term[1], exp_term[2], 1'b0, exp_wiper};
    act = {sw_a_en, sw_w_en, sw_b_en, w_to_b_short, wiper_code};
    n_vec = n_vec + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual a/w/b/short/wiper=%b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    if (sel) exp_wiper = d; else exp_term = d[3:0];
  endtask

  task automatic set_pin(input logic v);
    shdn_n = v;
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; shdn_n = 1'b1; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
    exp_term = 4'b0111; exp_wiper = 8'h80;
    repeat (3) @(negedge clk);
    check("R1 in reset", 1'b1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after reset", 1'b1);

    // R11: exact two-edge latency on entry and exit
    shdn_n = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R11 one edge after pin low", 1'b1);
    @(posedge clk); @(negedge clk);
    check("R11 two edges after pin low", 1'b0);
    shdn_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R11 one edge after pin high", 1'b0);
    @(posedge clk); @(negedge clk);
    check("R11 two edges after pin high", 1'b1);

    // R2 R4 R5 R6 R7: all terminal words against both pin levels
    for (int t = 0; t < 16; t++) begin
      wr(1'b0, 8'(t));
      check("R2 R5 R6 word loaded", 1'b1);
      set_pin(1'b0);
      check("R4 pin forces", 1'b0);
      set_pin(1'b1);
      check("R7 bits restored after pin", 1'b1);
    end

    // R9: writes during pin shutdown take effect on exit
    wr(1'b0, 8'h07);
    set_pin(1'b0);
    wr(1'b0, 8'h05);
    wr(1'b1, 8'h33);
    check("R9 write during shutdown, still forced", 1'b0);
    set_pin(1'b1);
    check("R9 written bits take effect on exit", 1'b1);

    // R9 R5: writes under software shutdown
    wr(1'b0, 8'h08);
    wr(1'b1, 8'hC4);
    check("R9 wiper write under soft shutdown", 1'b1);
    wr(1'b0, 8'h02);
    check("R5 R7 soft exit", 1'b1);

    // R3 R8 R10: full wiper sweep with pin alternating
    wr(1'b0, 8'h07);
    for (int w = 0; w < 256; w++) begin
      wr(1'b1, 8'(w));
      check("R3 wiper load", 1'b1);
      if (w % 16 == 0) begin
        set_pin(1'b0);
        check("R8 R10 wiper kept in shutdown", 1'b0);
        set_pin(1'b1);
        check("R8 wiper kept after exit", 1'b1);
      end
    end

    // R8: terminal writes leave the wiper alone
    wr(1'b1, 8'h5A);
    wr(1'b0, 8'h0F);
    wr(1'b0, 8'h00);
    check("R8 terminal write leaves wiper", 1'b1);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule